// File: doc/BRIEF.md
# Vectored Interrupt Controller with Fast and Normal Outputs

This block collects 32 level-sensitive interrupt lines. A software-writable request bit can raise each line as well as its pin. An enable mask gates every line. A steering bit then routes the line to either the fast output (`fiq_o`) or the normal output (`irq_o`). Both outputs are registered.

For the normal path, sixteen ranked vector slots each bind one source number to a handler address. Reading the current-vector register gives the address of the best matching slot, or a default address when no slot matches. A read of a matching slot also marks that slot as in service. While a slot is in service, it and every slot ranked below it are shut out, but higher-ranked slots can still pre-empt it. Writing the current-vector register ends the most recent service.

All state is reached through a single-cycle register bus. A read returns data combinationally in the same cycle. A write takes effect at the clock edge that ends the cycle. A guard bit can restrict the bus to privileged accesses.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The raw register (offset 0x00) reads as the bitwise OR of the `src_i` pins and the software request bits.
- R2: The normal status register (0x04) reads raw & enable & ~steer. The fast status register (0x08) reads raw & enable & steer.
- R3: Writing ones to 0x0C sets those enable bits, and writing ones to 0x10 clears them. Zero bits leave the enable unchanged. A read of 0x0C returns the enable mask.
- R4: Writing ones to 0x14 sets software request bits, and writing ones to 0x18 clears them. A read of 0x14 returns the request bits. A request reaches status only through the enable mask.
- R5: The steer register (0x1C) is read/write. A 1 in a bit routes that source to the fast path, and a 0 routes it to the normal path.
- R6: `irq_o` is the OR of normal status and `fiq_o` is the OR of fast status, each delayed through one register. Each output changes one cycle after its status changes.
- R7: Slot n has its handler address at 0x40+4n and its control word at 0x80+4n. In the control word, bits [4:0] hold the source number and bit 5 is the enable. A read of 0x24 returns the address of the lowest-numbered enabled slot whose source is set in normal status. When no slot qualifies, the read returns the default address held at 0x28.
- R8: A read of 0x24 that returns a slot address marks that slot as in service. Slots at or below the lowest-numbered in-service slot cannot match. Any write to 0x24 releases the lowest-numbered in-service slot.
- R9: A read of 0x24 that returns the default address marks the default as in service only when nothing else is in service. Otherwise the read has no side effect.
- R10: Writes to the raw and status registers are ignored. Reads of 0x10, 0x18, unmapped or unaligned offsets, and any read during a write return zero.
- R11: The guard register (0x20, bit 0) controls privilege. While it is set, accesses with `bus_priv_i` low are ignored: writes have no effect, reads return zero, and a read of 0x24 has no side effect.
- R12: After reset, all registers read zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level interrupt sources |
| bus_sel_i | input | 1 | Bus access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_priv_i | input | 1 | Access is privileged |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Read data is due in the same cycle as the access. Register writes, and the in-service marking caused by a vector read, become visible from the following cycle. `irq_o` and `fiq_o` follow one further cycle after the status they summarise. The bench drives the bus on the falling edge and samples one nanosecond later, which is well before the next rising edge. Each output check is placed in the cycle the latency predicts, and the check one cycle earlier confirms that the output has not yet moved.

// File: rtl/irq_vec_pkg.sv
`timescale 1ns/1ps
package irq_vec_pkg;
  localparam int SRC_N     = 32;
  localparam int SLOT_N    = 16;
  localparam int REG_AW    = 8;
  localparam int SRC_IDX_W = $clog2(SRC_N);

  localparam logic [REG_AW-1:0] OFS_RAW      = 8'h00;
  localparam logic [REG_AW-1:0] OFS_IRQ_ST   = 8'h04;
  localparam logic [REG_AW-1:0] OFS_FIQ_ST   = 8'h08;
  localparam logic [REG_AW-1:0] OFS_EN_SET   = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_EN_CLR   = 8'h10;
  localparam logic [REG_AW-1:0] OFS_SW_SET   = 8'h14;
  localparam logic [REG_AW-1:0] OFS_SW_CLR   = 8'h18;
  localparam logic [REG_AW-1:0] OFS_STEER    = 8'h1C;
  localparam logic [REG_AW-1:0] OFS_GUARD    = 8'h20;
  localparam logic [REG_AW-1:0] OFS_VEC_CUR  = 8'h24;
  localparam logic [REG_AW-1:0] OFS_VEC_DFLT = 8'h28;

  // Upper address bits select a region of the map
  typedef enum logic [1:0] {
    RG_CORE  = 2'd0,
    RG_VADDR = 2'd1,
    RG_VCTL  = 2'd2,
    RG_NONE  = 2'd3
  } region_e;
endpackage

// File: rtl/irq_src_bank.sv
`timescale 1ns/1ps
module irq_src_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] wdata_i,
  input  logic         en_set_we_i,
  input  logic         en_clr_we_i,
  input  logic         sw_set_we_i,
  input  logic         sw_clr_we_i,
  input  logic         steer_we_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] sw_o,
  output logic [N-1:0] steer_o,
  output logic [N-1:0] irq_stat_o,
  output logic [N-1:0] fiq_stat_o,
  output logic         irq_o,
  output logic         fiq_o
);
  logic [N-1:0] en_q, sw_q, steer_q;
  logic         irq_q, fiq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      sw_q    <= '0;
      steer_q <= '0;
      irq_q   <= 1'b0;
      fiq_q   <= 1'b0;
    end else begin
      if (en_set_we_i)      en_q <= en_q | wdata_i;
      else if (en_clr_we_i) en_q <= en_q & ~wdata_i;
      if (sw_set_we_i)      sw_q <= sw_q | wdata_i;
      else if (sw_clr_we_i) sw_q <= sw_q & ~wdata_i;
      if (steer_we_i)       steer_q <= wdata_i;
      irq_q <= |irq_stat_o;
      fiq_q <= |fiq_stat_o;
    end
  end

  for (genvar b = 0; b < N; b++) begin : g_bit
    assign raw_o[b]      = src_i[b] | sw_q[b];
    assign irq_stat_o[b] = raw_o[b] & en_q[b] & ~steer_q[b];
    assign fiq_stat_o[b] = raw_o[b] & en_q[b] &  steer_q[b];
  end

  assign en_o    = en_q;
  assign sw_o    = sw_q;
  assign steer_o = steer_q;
  assign irq_o   = irq_q;
  assign fiq_o   = fiq_q;

  p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_we_i |=> ((en_o & $past(wdata_i)) == $past(wdata_i)));
  p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr_we_i && !en_set_we_i) |=> ((en_o & $past(wdata_i)) == '0));
  p_sw_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_we_i && !sw_set_we_i) |=> ((sw_o & $past(wdata_i)) == '0));
  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(raw_o & en_o & ~steer_o)));
  p_fiq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> $past(|(raw_o & en_o & steer_o)));
endmodule

// File: rtl/irq_vec_slots.sv
`timescale 1ns/1ps
module irq_vec_slots #(
  parameter int SLOTS = 16,
  parameter int AW    = 32,
  parameter int NSRC  = 32,
  localparam int IW   = $clog2(SLOTS),
  localparam int SW   = $clog2(NSRC)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            irq_stat_i,
  input  logic [AW-1:0]              wdata_i,
  input  logic [SLOTS-1:0]           addr_we_i,
  input  logic [SLOTS-1:0]           ctl_we_i,
  input  logic                       dflt_we_i,
  input  logic                       ack_rd_i,
  input  logic                       ack_wr_i,
  output logic [SLOTS-1:0][AW-1:0]   slot_addr_o,
  output logic [SLOTS-1:0][SW:0]     slot_ctl_o,
  output logic [AW-1:0]              dflt_o,
  output logic [AW-1:0]              cur_addr_o
);
  logic [SLOTS-1:0][AW-1:0] addr_q;
  logic [SLOTS-1:0][SW:0]   ctl_q;
  logic [AW-1:0]            dflt_q;
  logic [SLOTS:0]           in_svc;
  logic [SLOTS-1:0]         active, shut, eligible;
  logic                     hit, any_svc;
  logic [IW-1:0]            win;

  for (genvar n = 0; n < SLOTS; n++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[n] <= '0;
        ctl_q[n]  <= '0;
      end else begin
        if (addr_we_i[n]) addr_q[n] <= wdata_i;
        if (ctl_we_i[n])  ctl_q[n]  <= wdata_i[SW:0];
      end
    end
    assign active[n] = ctl_q[n][SW] & irq_stat_i[ctl_q[n][SW-1:0]];
    if (n == 0) begin : g_first
      assign shut[n] = in_svc[0];
    end else begin : g_rest
      assign shut[n] = shut[n-1] | in_svc[n];
    end
  end

  assign eligible = active & ~shut;
  assign any_svc  = |in_svc;

  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        hit = 1'b1;
        win = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dflt_q <= '0;
      in_svc <= '0;
    end else begin
      if (dflt_we_i) dflt_q <= wdata_i;
      if (ack_rd_i) begin
        if (hit)           in_svc[win]   <= 1'b1;
        else if (!any_svc) in_svc[SLOTS] <= 1'b1;
      end else if (ack_wr_i) begin
        in_svc <= in_svc & (in_svc - (SLOTS+1)'(1));
      end
    end
  end

  assign slot_addr_o = addr_q;
  assign slot_ctl_o  = ctl_q;
  assign dflt_o      = dflt_q;
  assign cur_addr_o  = hit ? addr_q[win] : dflt_q;

  p_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd_i && hit) |=> in_svc[$past(win)]);
  p_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr_i && !ack_rd_i && any_svc) |=> ($countones(in_svc) == $countones($past(in_svc)) - 1));
  p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd_i && !hit && any_svc) |=> (in_svc == $past(in_svc)));
  p_only_higher_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd_i && hit && any_svc) |=> ($countones(in_svc) == $countones($past(in_svc)) + 1));
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int N_SRC  = SRC_N,
  parameter int N_SLOT = SLOT_N,
  parameter int RA     = REG_AW,
  localparam int DW    = N_SRC,
  localparam int IW    = $clog2(N_SLOT),
  localparam int SH    = IW + 2,
  localparam int SW    = $clog2(N_SRC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src_i,
  input  logic          bus_sel_i,
  input  logic          bus_wr_i,
  input  logic          bus_priv_i,
  input  logic [RA-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o,
  output logic          fiq_o
);
  logic                     guard_q;
  logic                     acc_ok, wr, rd;
  region_e                  region;
  logic [IW-1:0]            idx;
  logic [DW-1:0]            raw, en, sw, steer, irq_stat, fiq_stat;
  logic [N_SLOT-1:0]        addr_we, ctl_we;
  logic [N_SLOT-1:0][DW-1:0] slot_addr;
  logic [N_SLOT-1:0][SW:0]  slot_ctl;
  logic [DW-1:0]            dflt, cur_addr;

  assign acc_ok = bus_sel_i && (bus_priv_i || !guard_q) && (bus_addr_i[1:0] == 2'b00);
  assign wr     = acc_ok && bus_wr_i;
  assign rd     = acc_ok && !bus_wr_i;
  assign region = region_e'(bus_addr_i[RA-1:SH]);
  assign idx    = bus_addr_i[SH-1:2];

  for (genvar n = 0; n < N_SLOT; n++) begin : g_we
    assign addr_we[n] = wr && (region == RG_VADDR) && (idx == IW'(n));
    assign ctl_we[n]  = wr && (region == RG_VCTL)  && (idx == IW'(n));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              guard_q <= 1'b0;
    else if (wr && bus_addr_i == OFS_GUARD)  guard_q <= bus_wdata_i[0];
  end

  irq_src_bank #(.N(DW)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src_i),
    .wdata_i     (bus_wdata_i),
    .en_set_we_i (wr && bus_addr_i == OFS_EN_SET),
    .en_clr_we_i (wr && bus_addr_i == OFS_EN_CLR),
    .sw_set_we_i (wr && bus_addr_i == OFS_SW_SET),
    .sw_clr_we_i (wr && bus_addr_i == OFS_SW_CLR),
    .steer_we_i  (wr && bus_addr_i == OFS_STEER),
    .raw_o       (raw),
    .en_o        (en),
    .sw_o        (sw),
    .steer_o     (steer),
    .irq_stat_o  (irq_stat),
    .fiq_stat_o  (fiq_stat),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o)
  );

  irq_vec_slots #(.SLOTS(N_SLOT), .AW(DW), .NSRC(N_SRC)) u_slots (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_stat_i  (irq_stat),
    .wdata_i     (bus_wdata_i),
    .addr_we_i   (addr_we),
    .ctl_we_i    (ctl_we),
    .dflt_we_i   (wr && bus_addr_i == OFS_VEC_DFLT),
    .ack_rd_i    (rd && bus_addr_i == OFS_VEC_CUR),
    .ack_wr_i    (wr && bus_addr_i == OFS_VEC_CUR),
    .slot_addr_o (slot_addr),
    .slot_ctl_o  (slot_ctl),
    .dflt_o      (dflt),
    .cur_addr_o  (cur_addr)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      case (region)
        RG_VADDR: bus_rdata_o = slot_addr[idx];
        RG_VCTL:  bus_rdata_o = DW'(slot_ctl[idx]);
        RG_CORE: begin
          case (bus_addr_i)
            OFS_RAW:      bus_rdata_o = raw;
            OFS_IRQ_ST:   bus_rdata_o = irq_stat;
            OFS_FIQ_ST:   bus_rdata_o = fiq_stat;
            OFS_EN_SET:   bus_rdata_o = en;
            OFS_SW_SET:   bus_rdata_o = sw;
            OFS_STEER:    bus_rdata_o = steer;
            OFS_GUARD:    bus_rdata_o = DW'(guard_q);
            OFS_VEC_CUR:  bus_rdata_o = cur_addr;
            OFS_VEC_DFLT: bus_rdata_o = dflt;
            default:      bus_rdata_o = '0;
          endcase
        end
        default: bus_rdata_o = '0;
      endcase
    end
  end

  p_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_q && bus_sel_i && !bus_priv_i && bus_wr_i) |=> (en == $past(en) && steer == $past(steer)));
  p_guard_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_q && bus_sel_i && !bus_priv_i) |-> (bus_rdata_o == '0));
  p_wr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_wr_i) |-> (bus_rdata_o == '0));
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        sel = 1'b0, wr = 1'b0, priv = 1'b1;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, fiq_o;

  int errs = 0;
  int checks = 0;
  logic        mon_req = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_priv_i(priv),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares read data against the queued expectation
  initial forever begin
    @(negedge clk);
    #1;
    if (mon_req) check(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic p = 1'b1);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d; priv = p;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; priv = 1'b1;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag, input logic p = 1'b1);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a; priv = p;
    exp_q.push_back(e); tag_q.push_back(tag); mon_req = 1'b1;
    @(negedge clk);
    sel = 1'b0; mon_req = 1'b0; priv = 1'b1;
  endtask

  task automatic pins(input logic ei, input logic ef, input string tag);
    #1;
    check({tag, " irq_o"}, {31'b0, irq_o}, {31'b0, ei});
    check({tag, " fiq_o"}, {31'b0, fiq_o}, {31'b0, ef});
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    pins(1'b0, 1'b0, "R12 reset");
    bus_read(8'h00, 32'h0, "R12 raw");
    bus_read(8'h0C, 32'h0, "R12 enable");
    bus_read(8'h1C, 32'h0, "R12 steer");
    bus_read(8'h14, 32'h0, "R12 sw");
    bus_read(8'h28, 32'h0, "R12 default");

    @(negedge clk); src = 32'h11;
    bus_read(8'h00, 32'h11, "R1 raw from pins");
    bus_read(8'h04, 32'h0, "R2 masked status");
    bus_write(8'h0C, 32'h01);
    pins(1'b0, 1'b0, "R6 not yet");
    @(negedge clk);
    pins(1'b1, 1'b0, "R6 one cycle later");
    bus_write(8'h0C, 32'h10);
    bus_read(8'h0C, 32'h11, "R3 set keeps other bits");
    bus_read(8'h04, 32'h11, "R2 irq status");
    bus_write(8'h1C, 32'h10);
    bus_read(8'h1C, 32'h10, "R5 steer readback");
    bus_read(8'h04, 32'h01, "R5 irq status after steer");
    bus_read(8'h08, 32'h10, "R2 fiq status");
    pins(1'b1, 1'b1, "R6 both");
    bus_write(8'h10, 32'h01);
    bus_read(8'h0C, 32'h10, "R3 clear");
    bus_read(8'h04, 32'h0, "R3 status after clear");
    pins(1'b0, 1'b1, "R6 irq dropped");

    bus_write(8'h14, 32'h100);
    bus_read(8'h14, 32'h100, "R4 sw set");
    bus_read(8'h00, 32'h111, "R1 raw includes sw");
    bus_read(8'h04, 32'h0, "R4 sw masked by enable");
    bus_write(8'h18, 32'h100);
    bus_read(8'h00, 32'h11, "R4 sw clear");

    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h00, 32'h11, "R10 raw write ignored");
    bus_read(8'h10, 32'h0, "R10 enclr reads zero");
    bus_read(8'h18, 32'h0, "R10 swclr reads zero");
    bus_read(8'h3C, 32'h0, "R10 unmapped");
    bus_read(8'h0D, 32'h0, "R10 unaligned");

    // Vector slots
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h1C, 32'h0);
    @(negedge clk); src = 32'h0;
    bus_write(8'h0C, 32'hFF);
    bus_write(8'h40, 32'hA000);
    bus_write(8'h44, 32'hA100);
    bus_write(8'h4C, 32'hA300);
    bus_write(8'h80, 32'h25);
    bus_write(8'h84, 32'h07);
    bus_write(8'h8C, 32'h22);
    bus_write(8'h28, 32'hD000);
    bus_read(8'h4C, 32'hA300, "R7 slot address readback");
    bus_read(8'h8C, 32'h22, "R7 slot control readback");
    bus_read(8'h24, 32'hD000, "R7 default when idle");
    bus_write(8'h24, 32'h0);
    bus_write(8'h14, 32'h84);
    bus_read(8'h24, 32'hA300, "R7 disabled slot skipped");
    bus_read(8'h24, 32'hD000, "R8 served slot masked");
    bus_write(8'h14, 32'h20);
    bus_read(8'h24, 32'hA000, "R8 higher slot nests");
    bus_read(8'h24, 32'hD000, "R9 default no mark");
    bus_write(8'h24, 32'h0);
    bus_read(8'h24, 32'hA000, "R9 release pops top slot");
    bus_write(8'h24, 32'h0);
    bus_write(8'h24, 32'h0);
    bus_write(8'h18, 32'h20);
    bus_read(8'h24, 32'hA300, "R8 all released");
    bus_write(8'h24, 32'h0);

    // Guard
    bus_write(8'h20, 32'h1);
    bus_write(8'h0C, 32'hFFFF_0000, 1'b0);
    bus_read(8'h0C, 32'hFF, "R11 unprivileged write ignored");
    bus_read(8'h0C, 32'h0, "R11 unprivileged read zero", 1'b0);
    bus_read(8'h24, 32'h0, "R11 unprivileged vector read", 1'b0);
    bus_read(8'h24, 32'hA300, "R11 no side effect");
    bus_write(8'h24, 32'h0);
    bus_write(8'h20, 32'h0, 1'b0);
    bus_read(8'h20, 32'h1, "R11 guard held");

    repeat (2) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    summary();
  end
endmodule